// File: doc/BRIEF.md
# Pulse Interval Current Estimator

A recycling integrator turns a detector current into a train of pulses. Each pulse stands for a fixed quantum of charge, so the current is that charge divided by the time between two pulses. A time-to-digital converter stamps every pulse with a 1 ns count. This block takes those stamps and produces two kinds of result. The first is fast: the interval between the two most recent pulses. A later stage turns that interval into a current estimate by taking its reciprocal. The estimate is ready within one pulse and resolves better than 10 bits.

The block raises a loss alarm when an interval is shorter than a programmed minimum, because short intervals mean high current. When no pulse arrives for a programmed number of cycles, it reports a saturated interval, which stands for near-zero current. The slow results are pulse counts. One is a saturating total, used as an integrated-dose measure. The other is a per-gate count, latched at the end of each programmable gate period, for the classic counter readout. That readout needs a long gate: 128 pulses at full current for 7-bit resolution. This is why the fast interval path exists.

Top module: `pulse_interval_est`

## Requirements
- R1: While `rst` is high and after it is released, before any stimulus, `intv_valid`, `intv_value`, `intv_alarm`, `intv_timeout`, `total_count`, `win_valid` and `win_count` are all zero.
- R2: The first `ts_valid` after reset only stores the reference timestamp. It produces no `intv_valid`.
- R3: Every later `ts_valid` sampled at a clock edge sets `intv_valid` high for exactly the next cycle. `intv_value` = new timestamp − previous timestamp, modulo 2^TS_W, so a counter wrap still gives the correct short interval.
- R4: `intv_alarm` is high in the same cycle as a non-timeout `intv_valid` exactly when `intv_value` < `cfg_min_intv` (strictly less). It is low at all other times.
- R5: A reference is held and the last pulse was sampled at edge k. If no pulse is sampled at edges k+1 .. k+T+1, where T = `cfg_timeout`, then after edge k+T+1 `intv_valid` and `intv_timeout` are high for one cycle, with `intv_value` all ones and `intv_alarm` low. This happens once per gap, and never before the first pulse.
- R6: `total_count` rises by one for every sampled `ts_valid`, including the first, visible one cycle later. It holds at its all-ones maximum instead of wrapping.
- R7: Gates of `cfg_gate_len` cycles (0 acts as 1) run back to back from the first edge after reset. On the last edge of a gate, `win_count` takes the number of pulses sampled during that gate, including that edge, and `win_valid` pulses for one cycle. The next gate then starts counting from zero.
- R8: A gate count holds at the all-ones maximum of WIN_W bits instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_valid | input | 1 | Pulse timestamp strobe |
| ts_value | input | TS_W | Pulse timestamp in TDC units |
| cfg_min_intv | input | TS_W | Alarm threshold on the interval |
| cfg_timeout | input | TS_W | Idle cycles before a saturated interval is reported |
| cfg_gate_len | input | GATE_W | Gate length in cycles |
| intv_valid | output | 1 | Interval result strobe |
| intv_value | output | TS_W | Latest interval, all ones on timeout |
| intv_alarm | output | 1 | Interval below threshold |
| intv_timeout | output | 1 | Result is a timeout |
| total_count | output | TOT_W | Saturating total pulse count |
| win_valid | output | 1 | Gate count strobe |
| win_count | output | WIN_W | Pulse count of the last gate |

## Verification
Interval results, alarm and total count are all registered once. The bench drives a stimulus on a falling edge and checks its result on the very next falling edge; it also checks the strobe's drop one cycle later. The timeout result is due T+1 edges after the last sampled pulse. That test steps cycle by cycle and requires the strobe exactly on that step and nowhere else. Gate results are due on edge L, 2L and so on, counted from reset release. The gate tests reset first, number every edge, and place pulses on chosen edges, including the closing edge.

// File: rtl/pie_pkg.sv
`timescale 1ns/1ps
package pie_pkg;
    localparam int DEF_TS_W   = 32;
    localparam int DEF_TOT_W  = 24;
    localparam int DEF_WIN_W  = 16;
    localparam int DEF_GATE_W = 24;

    typedef enum logic {REF_EMPTY, REF_HELD} ref_state_e;

    typedef struct packed {
        logic valid;
        logic alarm;
        logic timeout;
    } intv_flags_t;
endpackage

// File: rtl/pie_interval_unit.sv
`timescale 1ns/1ps
module pie_interval_unit
    import pie_pkg::*;
#(
    parameter int TS_W = DEF_TS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ts_valid,
    input  logic [TS_W-1:0] ts_value,
    input  logic [TS_W-1:0] cfg_min_intv,
    input  logic [TS_W-1:0] cfg_timeout,
    output logic [TS_W-1:0] intv_value,
    output intv_flags_t     flags
);
    ref_state_e      state;
    logic [TS_W-1:0] prev_ts;
    logic [TS_W-1:0] idle_cnt;
    logic            fired;
    logic [TS_W-1:0] diff;

    always_comb diff = ts_value - prev_ts;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= REF_EMPTY;
            prev_ts    <= '0;
            idle_cnt   <= '0;
            fired      <= 1'b0;
            intv_value <= '0;
            flags      <= '0;
        end else begin
            flags <= '0;
            if (ts_valid) begin
                prev_ts  <= ts_value;
                idle_cnt <= '0;
                fired    <= 1'b0;
                state    <= REF_HELD;
                if (state == REF_HELD) begin
                    intv_value  <= diff;
                    flags.valid <= 1'b1;
                    flags.alarm <= (diff < cfg_min_intv);
                end
            end else if (state == REF_HELD && !fired) begin
                if (idle_cnt == cfg_timeout) begin
                    fired         <= 1'b1;
                    intv_value    <= '1;
                    flags.valid   <= 1'b1;
                    flags.timeout <= 1'b1;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pie_sat_counter.sv
`timescale 1ns/1ps
module pie_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc && count != CMAX)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/pie_gate_window.sv
`timescale 1ns/1ps
module pie_gate_window #(
    parameter int GATE_W = 8,
    parameter int WIN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse,
    input  logic [GATE_W-1:0] cfg_gate_len,
    output logic              win_valid,
    output logic [WIN_W-1:0]  win_count
);
    localparam int              EXT_W = GATE_W + 1;
    localparam logic [WIN_W-1:0] WMAX = '1;

    logic [GATE_W-1:0] gate_cnt;
    logic [WIN_W-1:0]  acc;
    logic              gate_end;

    always_comb gate_end = ({1'b0, gate_cnt} + EXT_W'(1)) >= {1'b0, cfg_gate_len};

    pie_sat_counter #(.W(WIN_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (gate_end),
        .inc   (pulse),
        .count (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_cnt  <= '0;
            win_valid <= 1'b0;
            win_count <= '0;
        end else begin
            win_valid <= gate_end;
            if (gate_end) begin
                gate_cnt  <= '0;
                win_count <= (pulse && acc != WMAX) ? acc + 1'b1 : acc;
            end else begin
                gate_cnt <= gate_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pulse_interval_est.sv
`timescale 1ns/1ps
module pulse_interval_est
    import pie_pkg::*;
#(
    parameter int TS_W   = DEF_TS_W,
    parameter int TOT_W  = DEF_TOT_W,
    parameter int WIN_W  = DEF_WIN_W,
    parameter int GATE_W = DEF_GATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ts_valid,
    input  logic [TS_W-1:0]   ts_value,
    input  logic [TS_W-1:0]   cfg_min_intv,
    input  logic [TS_W-1:0]   cfg_timeout,
    input  logic [GATE_W-1:0] cfg_gate_len,
    output logic              intv_valid,
    output logic [TS_W-1:0]   intv_value,
    output logic              intv_alarm,
    output logic              intv_timeout,
    output logic [TOT_W-1:0]  total_count,
    output logic              win_valid,
    output logic [WIN_W-1:0]  win_count
);
    intv_flags_t flags;

    pie_interval_unit #(.TS_W(TS_W)) u_intv (
        .clk          (clk),
        .rst          (rst),
        .ts_valid     (ts_valid),
        .ts_value     (ts_value),
        .cfg_min_intv (cfg_min_intv),
        .cfg_timeout  (cfg_timeout),
        .intv_value   (intv_value),
        .flags        (flags)
    );

    always_comb begin
        intv_valid   = flags.valid;
        intv_alarm   = flags.alarm;
        intv_timeout = flags.timeout;
    end

    pie_sat_counter #(.W(TOT_W)) u_total (
        .clk   (clk),
        .rst   (rst),
        .clr   (1'b0),
        .inc   (ts_valid),
        .count (total_count)
    );

    pie_gate_window #(.GATE_W(GATE_W), .WIN_W(WIN_W)) u_win (
        .clk          (clk),
        .rst          (rst),
        .pulse        (ts_valid),
        .cfg_gate_len (cfg_gate_len),
        .win_valid    (win_valid),
        .win_count    (win_count)
    );
endmodule

// File: rtl/pie_checker.sv
`timescale 1ns/1ps
module pie_checker #(
    parameter int TS_W  = 32,
    parameter int TOT_W = 24,
    parameter int WIN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ts_valid,
    input logic             intv_valid,
    input logic [TS_W-1:0]  intv_value,
    input logic             intv_alarm,
    input logic             intv_timeout,
    input logic [TOT_W-1:0] total_count,
    input logic             win_valid,
    input logic [WIN_W-1:0] win_count
);
    localparam logic [TOT_W-1:0] TMAX = '1;

    assert_measured_needs_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (intv_valid && !intv_timeout) |-> $past(ts_valid));

    assert_alarm_with_result_R4: assert property (@(posedge clk) disable iff (rst)
        intv_alarm |-> (intv_valid && !intv_timeout));

    assert_timeout_saturated_R5: assert property (@(posedge clk) disable iff (rst)
        intv_timeout |-> (intv_valid && intv_value == '1 && !$past(ts_valid)));

    assert_total_holds_max_R6: assert property (@(posedge clk) disable iff (rst)
        (total_count == TMAX) |=> (total_count == TMAX));

    assert_total_monotonic_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (total_count >= $past(total_count)));

    assert_win_stable_between_R7: assert property (@(posedge clk) disable iff (rst)
        !win_valid |-> $stable(win_count));
endmodule

bind pulse_interval_est pie_checker #(.TS_W(TS_W), .TOT_W(TOT_W), .WIN_W(WIN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ts_valid     (ts_valid),
    .intv_valid   (intv_valid),
    .intv_value   (intv_value),
    .intv_alarm   (intv_alarm),
    .intv_timeout (intv_timeout),
    .total_count  (total_count),
    .win_valid    (win_valid),
    .win_count    (win_count)
);

// File: tb/pulse_interval_est_tb.sv
`timescale 1ns/1ps
module pulse_interval_est_tb;
    localparam int TS_W = 16, TOT_W = 4, WIN_W = 4, GATE_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ts_valid = 1'b0;
    logic [TS_W-1:0] ts_value = '0;
    logic [TS_W-1:0] cfg_min_intv = '0;
    logic [TS_W-1:0] cfg_timeout = '0;
    logic [GATE_W-1:0] cfg_gate_len = '0;
    logic intv_valid, intv_alarm, intv_timeout, win_valid;
    logic [TS_W-1:0] intv_value;
    logic [TOT_W-1:0] total_count;
    logic [WIN_W-1:0] win_count;

    int n_checks = 0;
    int n_fails = 0;

    always #10 clk = ~clk;

    pulse_interval_est #(.TS_W(TS_W), .TOT_W(TOT_W), .WIN_W(WIN_W), .GATE_W(GATE_W)) u_dut (
        .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_value(ts_value),
        .cfg_min_intv(cfg_min_intv), .cfg_timeout(cfg_timeout), .cfg_gate_len(cfg_gate_len),
        .intv_valid(intv_valid), .intv_value(intv_value), .intv_alarm(intv_alarm),
        .intv_timeout(intv_timeout), .total_count(total_count),
        .win_valid(win_valid), .win_count(win_count)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int mn, input int tmo, input int gl);
        @(negedge clk);
        cfg_min_intv = TS_W'(mn);
        cfg_timeout  = TS_W'(tmo);
        cfg_gate_len = GATE_W'(gl);
        rst = 1'b1;
        ts_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic tick(input logic v, input int ts);
        ts_valid = v;
        ts_value = TS_W'(ts);
        @(negedge clk);
        ts_valid = 1'b0;
    endtask

    task automatic test_reset_R1;
        do_reset(50, 1000, 100);
        chk("R1 intv_valid", intv_valid, 0);
        chk("R1 intv_value", intv_value, 0);
        chk("R1 alarm", intv_alarm, 0);
        chk("R1 timeout", intv_timeout, 0);
        chk("R1 total", total_count, 0);
        chk("R1 win_valid", win_valid, 0);
        chk("R1 win_count", win_count, 0);
    endtask

    task automatic test_interval_R2_R3_R4;
        do_reset(50, 1000, 200);
        tick(1, 100);
        chk("R2 no interval on first", intv_valid, 0);
        chk("R6 total after first", total_count, 1);
        tick(0, 0);
        chk("R2 still none", intv_valid, 0);
        tick(1, 350);
        chk("R3 valid", intv_valid, 1);
        chk("R3 value", intv_value, 250);
        chk("R4 no alarm above", intv_alarm, 0);
        tick(0, 0);
        chk("R3 one-cycle strobe", intv_valid, 0);
        tick(1, 400);
        chk("R4 equal is no alarm", intv_alarm, 0);
        chk("R3 value 50", intv_value, 50);
        tick(1, 449);
        chk("R4 below alarms", intv_alarm, 1);
        chk("R3 back-to-back valid", intv_valid, 1);
        tick(1, 16'hFFF0);
        chk("R3 large interval", intv_value, 65071);
        chk("R4 alarm clears", intv_alarm, 0);
        tick(1, 16'h0010);
        chk("R3 wrap interval", intv_value, 32);
        chk("R4 alarm on wrap", intv_alarm, 1);
        chk("R6 total count", total_count, 6);
    endtask

    task automatic test_timeout_R5;
        do_reset(50, 1000, 200);
        cfg_timeout = 16'd5;
        for (int j = 1; j <= 10; j++) begin
            tick(0, 0);
            chk("R5 none before reference", intv_valid, 0);
        end
        tick(1, 10);
        for (int j = 1; j <= 9; j++) begin
            tick(0, 0);
            chk("R5 strobe position", intv_valid, (j == 6) ? 1 : 0);
            chk("R5 flag position", intv_timeout, (j == 6) ? 1 : 0);
            chk("R5 alarm low", intv_alarm, 0);
            if (j == 6) chk("R5 saturated value", intv_value, 16'hFFFF);
        end
        tick(1, 500);
        chk("R3 after timeout", intv_value, 490);
        chk("R5 flag off on pulse", intv_timeout, 0);
    endtask

    task automatic test_total_sat_R6;
        do_reset(0, 1000, 200);
        for (int j = 1; j <= 20; j++) begin
            tick(1, j * 7);
            chk("R6 saturating total", total_count, (j > 15) ? 15 : j);
        end
    endtask

    task automatic test_window_R7;
        do_reset(0, 1000, 10);
        for (int j = 1; j <= 20; j++) begin
            tick((j == 3 || j == 5 || j == 10 || j == 11) ? 1'b1 : 1'b0, j);
            chk("R7 gate strobe", win_valid, (j == 10 || j == 20) ? 1 : 0);
            if (j == 10) chk("R7 first gate count", win_count, 3);
            if (j == 20) chk("R7 second gate count", win_count, 1);
        end
        do_reset(0, 1000, 0);
        tick(1, 1);
        chk("R7 zero len strobe", win_valid, 1);
        chk("R7 zero len count 1", win_count, 1);
        tick(0, 0);
        chk("R7 zero len count 0", win_count, 0);
    endtask

    task automatic test_window_sat_R8;
        do_reset(0, 1000, 40);
        for (int j = 1; j <= 40; j++) tick((j <= 20) ? 1'b1 : 1'b0, j);
        chk("R8 strobe", win_valid, 1);
        chk("R8 saturated gate count", win_count, 15);
    endtask

    initial begin
        fork
            begin
                test_reset_R1();
                test_interval_R2_R3_R4();
                test_timeout_R5();
                test_total_sat_R6();
                test_window_R7();
                test_window_sat_R8();
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule